// File: doc/BRIEF.md
# Infrared SIR Pulse Shaper with Low-Power Timing

This block sits between a UART and an infrared transceiver. On the transmit side it reads the UART bit stream and emits one short high pulse for each zero bit. One bits leave the line low. In normal mode the pulse width comes from the baud-16 enable. In low-power mode it is set by a separate timing tick, which is derived from the system clock by an 8-bit divisor.

On the receive side the infrared input passes through two synchroniser flip-flops. A pulse is then qualified against the same tick. Short spikes are dropped. An accepted pulse is widened into a full-bit-time low level on the UART receive line.

Software writes the divisor through a 32-bit configuration word and can read it back. The tick runs whenever the block is enabled, whichever mode is selected, because the receive qualifier depends on it in both modes.

Top module: `irda_sir_shaper`

## Requirements
- R1: After reset the divisor is 0, `cfg_rdata` reads 0, `sir_out` is low and `rx_bit` is high.
- R2: A write with `cfg_we` high stores `cfg_wdata[7:0]` as the divisor. `cfg_rdata[7:0]` returns the stored divisor and `cfg_rdata[31:8]` always reads 0, whatever was written there.
- R3: With divisor N (1 to 255) and `enable` high, the low-power tick occurs once every N system clocks. The first tick comes on the first enabled cycle.
- R4: A bit boundary is every 16th baud-16 enable while enabled, counted from the first one after enable rises. In normal mode (`low_power`=0), a zero on `tx_bit` at a bit boundary drives `sir_out` high from the next cycle until the cycle after the 4th enable of that bit, which is 3 enable intervals. A one bit gives no pulse.
- R5: In low-power mode, a zero bit arms the transmitter. The pulse starts on the cycle after the next tick and lasts exactly 3×N system clocks.
- R6: With divisor 0 no tick occurs. No low-power pulse is sent and no received pulse is accepted.
- R7: A received pulse is accepted only if the synchronised input is high on two successive ticks. A pulse of at most N cycles is always rejected, and one of 2×N cycles or more is always accepted.
- R8: Acceptance drives `rx_bit` low from the next cycle for 16 baud-16 enables. Then `rx_bit` returns high.
- R9: The receive qualifier works identically in normal mode.
- R10: While `enable` is low, `sir_out` stays low, the tick stops and the bit phase restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Block enable; low stops tick and transmitter |
| low_power | input | 1 | 1 selects tick-timed pulses, 0 selects 3/16-bit pulses |
| baud16_en | input | 1 | One-cycle strobe at 16 times the bit rate |
| tx_bit | input | 1 | UART transmit bit stream |
| sir_out | output | 1 | Infrared transmit pulse, active high |
| sir_in | input | 1 | Infrared receive pulse, active high, asynchronous |
| rx_bit | output | 1 | UART-level receive line, idles high |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read-back |

## Verification
The hardest situation to reach is a received pulse whose length lies near the qualifying limit. Whether such a pulse is accepted depends on where the free-running tick falls relative to its edges. The stimulus sends pulses of exactly N cycles, which must always be rejected, and of exactly 2×N cycles, which must always be accepted. A clock-by-clock reference model tracks the tick phase from the enable edge, so every intermediate outcome is also compared exactly. Divisor values of 1, 5 and 12 exercise the low-power pulse width. Divisor 0 is sent in both directions.

// File: rtl/irda_sir_pkg.sv
package irda_sir_pkg;

    localparam int unsigned DIV_W    = 8;
    localparam int unsigned OVS      = 16;
    localparam int unsigned PH_W     = $clog2(OVS);
    localparam int unsigned NRM_END  = 3;
    localparam int unsigned LP_TICKS = 3;
    localparam int unsigned LPC_W    = $clog2(LP_TICKS + 1);
    localparam int unsigned HOLD_W   = $clog2(OVS + 1);
    localparam int unsigned HIT_W    = 2;

    typedef enum logic {
        MODE_NORMAL = 1'b0,
        MODE_LOWPWR = 1'b1
    } sir_mode_e;

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic [DIV_W-1:0] cnt;
    } div_st_t;

    typedef struct packed {
        logic [PH_W-1:0]  phase;
        logic             armed;
        logic             pulse;
        logic [LPC_W-1:0] ticks;
    } tx_st_t;

    typedef struct packed {
        logic              s1;
        logic              s2;
        logic [HIT_W-1:0]  hits;
        logic [HOLD_W-1:0] hold;
    } rx_st_t;

endpackage

// File: rtl/sir_lp_divider.sv
module sir_lp_divider
    import irda_sir_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             wr_en,
    input  logic [DIV_W-1:0] wr_div,
    output logic [DIV_W-1:0] div_o,
    output logic             tick_o
);

    div_st_t st_d, st_q;
    logic    tick;

    always_comb begin
        st_d = st_q;
        tick = 1'b0;
        if (!enable || st_q.div == '0) begin
            st_d.cnt = '0;
        end else if (st_q.cnt <= DIV_W'(1)) begin
            // reload point: emit the tick and restart from the divisor
            tick     = 1'b1;
            st_d.cnt = st_q.div;
        end else begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
        if (wr_en) begin
            st_d.div = wr_div;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign div_o  = st_q.div;
    assign tick_o = tick;

endmodule

// File: rtl/sir_tx_enc.sv
module sir_tx_enc
    import irda_sir_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      enable,
    input  sir_mode_e mode,
    input  logic      baud16_en,
    input  logic      tick,
    input  logic      tx_bit,
    output logic      sir_o
);

    tx_st_t st_d, st_q;
    logic   bit_start;

    always_comb begin
        st_d      = st_q;
        bit_start = baud16_en && (st_q.phase == '0);
        if (!enable) begin
            st_d = '0;
        end else begin
            if (mode == MODE_NORMAL) begin
                st_d.armed = 1'b0;
                st_d.ticks = '0;
                if (bit_start && !tx_bit) begin
                    st_d.pulse = 1'b1;
                end else if (baud16_en && st_q.phase == PH_W'(NRM_END)) begin
                    st_d.pulse = 1'b0;
                end
            end else begin
                if (st_q.pulse) begin
                    if (tick) begin
                        if (st_q.ticks == LPC_W'(LP_TICKS - 1)) begin
                            st_d.pulse = 1'b0;
                            st_d.ticks = '0;
                        end else begin
                            st_d.ticks = st_q.ticks + 1'b1;
                        end
                    end
                end else if (st_q.armed && tick) begin
                    st_d.pulse = 1'b1;
                    st_d.armed = 1'b0;
                    st_d.ticks = '0;
                end
                if (bit_start) begin
                    st_d.armed = !tx_bit;
                end
            end
            if (baud16_en) begin
                st_d.phase = (st_q.phase == PH_W'(OVS - 1)) ? '0 : st_q.phase + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sir_o = st_q.pulse;

endmodule

// File: rtl/sir_rx_dec.sv
module sir_rx_dec
    import irda_sir_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic baud16_en,
    input  logic tick,
    input  logic sir_in,
    output logic sync_o,
    output logic rx_o
);

    rx_st_t st_d, st_q;
    logic   accept;

    always_comb begin
        st_d    = st_q;
        accept  = 1'b0;
        st_d.s1 = sir_in;
        st_d.s2 = st_q.s1;
        if (!st_q.s2) begin
            st_d.hits = '0;
        end else if (tick && st_q.hits != HIT_W'(2)) begin
            st_d.hits = st_q.hits + 1'b1;
            accept    = (st_q.hits == HIT_W'(1));
        end
        if (accept) begin
            st_d.hold = HOLD_W'(OVS);
        end else if (baud16_en && st_q.hold != '0) begin
            st_d.hold = st_q.hold - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sync_o = st_q.s2;
    assign rx_o   = (st_q.hold == '0);

endmodule

// File: rtl/irda_sir_shaper.sv
module irda_sir_shaper
    import irda_sir_pkg::*;
#(
    parameter int unsigned CFG_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             low_power,
    input  logic             baud16_en,
    input  logic             tx_bit,
    output logic             sir_out,
    input  logic             sir_in,
    output logic             rx_bit,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic [CFG_W-1:0] cfg_rdata
);

    localparam int unsigned RSVD_W = CFG_W - DIV_W;

    logic [DIV_W-1:0] lp_div;
    logic             lp_tick;
    logic             rx_sync;
    sir_mode_e        mode;

    assign mode = low_power ? MODE_LOWPWR : MODE_NORMAL;

    sir_lp_divider u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (enable),
        .wr_en  (cfg_we),
        .wr_div (cfg_wdata[DIV_W-1:0]),
        .div_o  (lp_div),
        .tick_o (lp_tick)
    );

    sir_tx_enc u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .mode      (mode),
        .baud16_en (baud16_en),
        .tick      (lp_tick),
        .tx_bit    (tx_bit),
        .sir_o     (sir_out)
    );

    sir_rx_dec u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .baud16_en (baud16_en),
        .tick      (lp_tick),
        .sir_in    (sir_in),
        .sync_o    (rx_sync),
        .rx_o      (rx_bit)
    );

    assign cfg_rdata = {{RSVD_W{1'b0}}, lp_div};

endmodule

// File: rtl/irda_sir_checker.sv
module irda_sir_checker
    import irda_sir_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             enable,
    input logic             low_power,
    input logic             baud16_en,
    input logic             sir_out,
    input logic             rx_bit,
    input logic             tick,
    input logic [DIV_W-1:0] div,
    input logic             sync_s
);

    logic [DIV_W+2:0] hi_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_cnt <= '0;
        end else begin
            hi_cnt <= sir_out ? hi_cnt + 1'b1 : '0;
        end
    end

    p_zero_div_no_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (div == '0) |-> !tick);

    p_nrm_rise_on_b16_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sir_out) && !low_power) |-> $past(baud16_en));

    p_lp_rise_on_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sir_out) && low_power) |-> $past(tick));

    p_lp_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sir_out) && low_power && enable) |-> (hi_cnt == 3 * {3'b000, div}));

    p_off_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !sir_out);

    p_rx_after_qualify_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rx_bit) |-> ($past(sync_s) && $past(tick)));

endmodule

bind irda_sir_shaper irda_sir_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .low_power (low_power),
    .baud16_en (baud16_en),
    .sir_out   (sir_out),
    .rx_bit    (rx_bit),
    .tick      (lp_tick),
    .div       (lp_div),
    .sync_s    (rx_sync)
);

// File: tb/tb_irda_sir_shaper.sv
module tb_irda_sir_shaper;

    localparam int B16_GAP = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        low_power = 1'b0;
    logic        baud16_en = 1'b0;
    logic        tx_bit = 1'b1;
    logic        sir_in = 1'b0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic        sir_out, rx_bit;
    logic [31:0] cfg_rdata;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    irda_sir_shaper dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .low_power(low_power),
        .baud16_en(baud16_en), .tx_bit(tx_bit), .sir_out(sir_out),
        .sir_in(sir_in), .rx_bit(rx_bit), .cfg_we(cfg_we),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata)
    );

    always #2 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // reference model, updated on each rising edge
    int m_div, m_k, m_ph, m_tk, m_hits, m_hold;
    bit m_armed, m_sir, m_s1, m_s2, tk_now, bs, acc;
    bit txq[$];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_div = 0; m_k = 0; m_ph = 0; m_tk = 0; m_hits = 0; m_hold = 0;
            m_armed = 0; m_sir = 0; m_s1 = 0; m_s2 = 0;
        end else begin
            tk_now = enable && (m_div != 0) && ((m_k % m_div) == 0);
            bs     = baud16_en && (m_ph == 0);
            acc    = 0;
            if (!m_s2) m_hits = 0;
            else if (tk_now && m_hits < 2) begin
                if (m_hits == 1) acc = 1;
                m_hits++;
            end
            if (acc) m_hold = 16;
            else if (baud16_en && m_hold > 0) m_hold--;
            m_s2 = m_s1;
            m_s1 = sir_in;
            if (!enable) begin
                m_ph = 0; m_armed = 0; m_sir = 0; m_tk = 0;
            end else begin
                if (!low_power) begin
                    m_armed = 0; m_tk = 0;
                    if (bs && !tx_bit) m_sir = 1;
                    else if (baud16_en && m_ph == 3) m_sir = 0;
                end else begin
                    if (m_sir) begin
                        if (tk_now) begin
                            m_tk++;
                            if (m_tk == 3) begin m_sir = 0; m_tk = 0; end
                        end
                    end else if (m_armed && tk_now) begin
                        m_sir = 1; m_armed = 0; m_tk = 0;
                    end
                    if (bs) m_armed = !tx_bit;
                end
                if (baud16_en) m_ph = (m_ph + 1) % 16;
            end
            m_k = enable ? m_k + 1 : 0;
            if (cfg_we) m_div = int'(cfg_wdata[7:0]);
        end
    end

    // stimulus: baud-16 strobe and bit stream, changed on falling edges
    int bcnt = 0;
    always @(negedge clk) begin
        baud16_en <= (bcnt == 0);
        if (bcnt == 0 && enable && m_ph == 0)
            tx_bit <= (txq.size() > 0) ? txq.pop_front() : 1'b1;
        bcnt = (bcnt + 1) % B16_GAP;
    end

    // per-clock comparison and pulse measurement
    int exp_w = 0, run_hi = 0, n_pulse = 0, run_lo = 0, n_rx = 0, last_lo = 0;
    bit prev_sir = 0, prev_rx = 1;
    always @(negedge clk) begin
        if (rst_n) begin
            chk(sir_out == m_sir, "R4 R5 sir_out model", int'(sir_out), int'(m_sir));
            chk(rx_bit == (m_hold == 0), "R8 rx_bit model", int'(rx_bit), int'(m_hold == 0));
            if (sir_out && !prev_sir) n_pulse++;
            if (sir_out) run_hi++;
            else if (run_hi > 0) begin
                if (exp_w != 0) chk(run_hi == exp_w, "R5 pulse width", run_hi, exp_w);
                run_hi = 0;
            end
            if (!rx_bit && prev_rx) n_rx++;
            if (!rx_bit) run_lo++;
            else if (run_lo > 0) begin last_lo = run_lo; run_lo = 0; end
            prev_sir = sir_out;
            prev_rx  = rx_bit;
        end
    end

    task automatic wr(input logic [31:0] v);
        @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk); cfg_we = 1'b0;
    endtask

    task automatic setup(input logic [31:0] v, input bit lp);
        @(negedge clk); enable = 1'b0;
        wr(v);
        low_power = lp;
        @(negedge clk); enable = 1'b1;
    endtask

    task automatic wait_bits(input int n);
        repeat (n * 16 * B16_GAP) @(negedge clk);
    endtask

    task automatic pulse_in(input int len);
        @(negedge clk); sir_in = 1'b1;
        repeat (len) @(negedge clk);
        sir_in = 1'b0;
    endtask

    task automatic tx_run(input int w, input string req);
        int p0;
        exp_w = w;
        p0 = n_pulse;
        txq = '{1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1};
        wait_bits(10);
        chk(n_pulse - p0 == 4, req, n_pulse - p0, 4);
    endtask

    int r0;

    initial begin
        repeat (5) @(negedge clk);
        // R1 reset values
        chk(cfg_rdata == 32'h0, "R1 rdata", int'(cfg_rdata), 0);
        chk(sir_out == 1'b0, "R1 sir_out", int'(sir_out), 0);
        chk(rx_bit == 1'b1, "R1 rx_bit", int'(rx_bit), 1);
        rst_n = 1'b1;
        @(negedge clk);
        // R2 read-back with reserved bits written
        wr(32'hABCD_EF05);
        chk(cfg_rdata == 32'h0000_0005, "R2 readback", int'(cfg_rdata), 5);
        // R4 normal mode: 3 enable intervals
        setup(32'h5, 1'b0);
        tx_run(3 * B16_GAP, "R4 normal pulse count");
        // R5 and R3 low-power widths for several divisors
        setup(32'h5, 1'b1);
        tx_run(15, "R5 lp pulses N=5");
        setup(32'hC, 1'b1);
        tx_run(36, "R3 lp pulses N=12");
        setup(32'h1, 1'b1);
        tx_run(3, "R5 lp pulses N=1");
        // R6 divisor zero: no pulses
        setup(32'hFFFF_FF00, 1'b1);
        chk(cfg_rdata == 32'h0, "R6 readback zero", int'(cfg_rdata), 0);
        exp_w = 0;
        r0 = n_pulse;
        txq = '{1'b0, 1'b0, 1'b0, 1'b0};
        wait_bits(6);
        chk(n_pulse == r0, "R6 no tx pulses", n_pulse - r0, 0);
        // R9 R7 receive filter in normal mode, N=12
        setup(32'hC, 1'b0);
        r0 = n_rx;
        pulse_in(6);
        wait_bits(2);
        chk(n_rx == r0, "R7 short glitch rejected", n_rx - r0, 0);
        pulse_in(12);
        wait_bits(2);
        chk(n_rx == r0, "R7 N-cycle pulse rejected", n_rx - r0, 0);
        pulse_in(24);
        wait_bits(2);
        chk(n_rx == r0 + 1, "R9 2N pulse accepted normal mode", n_rx - r0, 1);
        chk(last_lo > 15 * B16_GAP && last_lo <= 16 * B16_GAP, "R8 rx low width",
            last_lo, 16 * B16_GAP);
        // R7 low-power mode receive
        setup(32'hC, 1'b1);
        pulse_in(36);
        wait_bits(2);
        chk(n_rx == r0 + 2, "R7 long pulse accepted lp", n_rx - r0, 2);
        // R6 divisor zero receive
        setup(32'h0, 1'b0);
        pulse_in(100);
        wait_bits(2);
        chk(n_rx == r0 + 2, "R6 no rx accept", n_rx - r0, 2);
        // R10 disabled: queued zeros produce nothing
        setup(32'h5, 1'b0);
        @(negedge clk); enable = 1'b0;
        r0 = n_pulse;
        txq = '{1'b0, 1'b0};
        wait_bits(3);
        chk(n_pulse == r0, "R10 disabled quiet", n_pulse - r0, 0);
        chk(sir_out == 1'b0, "R10 sir_out low", int'(sir_out), 0);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule